// File: doc/BRIEF.md
# RGB Pixel Component Orderer

This block sits between a pixel stream and the data pins of an RGB LCD panel. It takes 24-bit pixels from a valid/ready stream. The input layout is red in bits 23:16, green in 15:8 and blue in 7:0. Each pixel is driven onto the panel data bus one pixel-clock cycle after it is accepted, together with a data-enable and a first-component marker.

The block has two parallel modes and two serial modes. In the parallel modes a whole pixel leaves in one cycle, in RGB or in BGR order. In the serial modes one 8-bit colour leaves per cycle over three cycles, in forward order (R, G, B) or in reverse order (B, G, R). The serial byte is driven on the low byte of the bus.

A 2-bit output selector says whether the panel uses the RGB interface. Only when the selector is 00 does the display-mode field apply. Any other selector value forces parallel RGB. The mode and the selector are sampled when a pixel is accepted, so a change never splits a serial triplet. Sync generation and timing counters belong to a neighbouring block.

Top module: `lcd_rgb_orderer`

## Requirements
- R1: After reset, lcd_de_o=0, lcd_first_o=0, lcd_data_o=0 and pix_ready_o=1.
- R2: With selector 00 and mode 00, an accepted pixel appears on the next cycle as {R,G,B} (R in bits 23:16, G in 15:8, B in 7:0), with lcd_de_o=1.
- R3: With selector 00 and mode 01, an accepted pixel appears on the next cycle as {B,G,R} (B in bits 23:16, R in 7:0).
- R4: With selector 00 and mode 10, an accepted pixel is sent as R, then G, then B on three consecutive cycles. Each byte is in bits 7:0, bits 23:8 are zero and lcd_de_o=1.
- R5: With selector 00 and mode 11, an accepted pixel is sent as B, then G, then R, in the same bus layout as R4.
- R6: When the selector is not 00 (01, 10 or 11), every pixel is sent in parallel {R,G,B} order, whatever the mode field holds.
- R7: In a serial mode, pix_ready_o is 0 while components of the current pixel are still pending. Under continuous valid input it is high one cycle in three. In a parallel mode pix_ready_o stays 1.
- R8: lcd_first_o is 1 on the first cycle of each serial triplet and on every parallel output cycle, and 0 on the other cycles.
- R9: A change of mode, selector or input data after a pixel is accepted does not alter that pixel's remaining components or their order.
- R10: On any cycle with no pixel being output, lcd_de_o=0 and lcd_data_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| out_sel_i | input | 2 | Output selector; 00 = RGB interface |
| disp_mode_i | input | 2 | 00 parallel RGB, 01 parallel BGR, 10 serial forward, 11 serial reverse |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_ready_o | output | 1 | Block can accept a pixel this cycle |
| pix_data_i | input | 24 | Input pixel {R,G,B} |
| lcd_data_o | output | 24 | Panel data bus |
| lcd_de_o | output | 1 | Panel data enable |
| lcd_first_o | output | 1 | First component of a pixel |

## Verification
The bench drives back-to-back serial pixels and checks two things there. A sequencer off by one in its count would either drop ready a cycle late, so the next pixel is taken over the last byte, or leave a gap in data-enable between triplets. It changes the mode, the selector and the input data in the middle of a triplet. A design that decodes the mode on every cycle instead of at acceptance would reverse or parallelise the rest of the pixel. It also feeds the serial mode codes with a non-RGB selector, where a design that ignores the selector would serialise, and it checks that idle cycles carry zero data rather than the last pixel.

// File: rtl/lcd_ord_pkg.sv
`timescale 1ns/1ps
package lcd_ord_pkg;
  typedef struct packed {
    logic serial;
    logic reverse;
  } ord_mode_t;
endpackage

// File: rtl/lcd_mode_decode.sv
`timescale 1ns/1ps
module lcd_mode_decode
  import lcd_ord_pkg::*;
(
  input  logic [1:0] out_sel_i,
  input  logic [1:0] disp_mode_i,
  output ord_mode_t  mode_o
);
  logic rgb_if;
  // non-RGB interfaces are forced to parallel RGB
  assign rgb_if         = (out_sel_i == 2'b00);
  assign mode_o.serial  = rgb_if & disp_mode_i[1];
  assign mode_o.reverse = rgb_if & disp_mode_i[0];
endmodule

// File: rtl/lcd_comp_order.sv
`timescale 1ns/1ps
module lcd_comp_order #(
  parameter int COMP_W = 8,
  parameter int N_COMP = 3,
  localparam int DATA_W = COMP_W * N_COMP
) (
  input  logic [DATA_W-1:0] pix_i,
  input  logic              reverse_i,
  output logic [COMP_W-1:0] comps_o [N_COMP]
);
  // comps_o[k] is the k-th component in send order
  for (genvar k = 0; k < N_COMP; k++) begin : g_comp
    assign comps_o[k] = reverse_i ? pix_i[k*COMP_W +: COMP_W]
                                  : pix_i[(N_COMP-1-k)*COMP_W +: COMP_W];
  end
endmodule

// File: rtl/lcd_serial_seq.sv
`timescale 1ns/1ps
module lcd_serial_seq #(
  parameter int N_COMP = 3,
  localparam int IDX_W = (N_COMP > 1) ? $clog2(N_COMP) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             serial_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o
);
  logic [IDX_W-1:0] left_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      idx_q  <= '0;
    end else if (start_i) begin
      left_q <= serial_i ? IDX_W'(N_COMP - 1) : '0;
      idx_q  <= '0;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign idx_o  = idx_q;
  assign busy_o = (left_q != '0);
endmodule

// File: rtl/lcd_rgb_orderer.sv
`timescale 1ns/1ps
module lcd_rgb_orderer
  import lcd_ord_pkg::*;
#(
  parameter int COMP_W = 8,
  parameter int N_COMP = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [1:0]                 out_sel_i,
  input  logic [1:0]                 disp_mode_i,
  input  logic                       pix_valid_i,
  output logic                       pix_ready_o,
  input  logic [COMP_W*N_COMP-1:0]   pix_data_i,
  output logic [COMP_W*N_COMP-1:0]   lcd_data_o,
  output logic                       lcd_de_o,
  output logic                       lcd_first_o
);
  localparam int DATA_W = COMP_W * N_COMP;
  localparam int IDX_W  = (N_COMP > 1) ? $clog2(N_COMP) : 1;

  ord_mode_t         mode_d, mode_q;
  logic [DATA_W-1:0] pix_q;
  logic              de_q;
  logic              accept;
  logic              busy;
  logic [IDX_W-1:0]  idx;
  logic [COMP_W-1:0] comps [N_COMP];
  logic [DATA_W-1:0] par_data;

  lcd_mode_decode u_dec (
    .out_sel_i   (out_sel_i),
    .disp_mode_i (disp_mode_i),
    .mode_o      (mode_d)
  );

  assign pix_ready_o = ~busy;
  assign accept      = pix_valid_i & pix_ready_o;

  lcd_serial_seq #(.N_COMP(N_COMP)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .serial_i (mode_d.serial),
    .idx_o    (idx),
    .busy_o   (busy)
  );

  // mode and pixel are captured only at acceptance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q  <= '0;
      mode_q <= '0;
      de_q   <= 1'b0;
    end else begin
      if (accept) begin
        pix_q  <= pix_data_i;
        mode_q <= mode_d;
      end
      de_q <= accept | busy;
    end
  end

  lcd_comp_order #(.COMP_W(COMP_W), .N_COMP(N_COMP)) u_ord (
    .pix_i     (pix_q),
    .reverse_i (mode_q.reverse),
    .comps_o   (comps)
  );

  for (genvar k = 0; k < N_COMP; k++) begin : g_par
    assign par_data[DATA_W-1-k*COMP_W -: COMP_W] = comps[k];
  end

  always_comb begin
    lcd_data_o = '0;
    if (de_q) begin
      if (mode_q.serial) lcd_data_o[COMP_W-1:0] = comps[idx];
      else               lcd_data_o = par_data;
    end
  end

  assign lcd_de_o    = de_q;
  assign lcd_first_o = de_q & (idx == '0);
endmodule

// File: rtl/lcd_rgb_orderer_chk.sv
`timescale 1ns/1ps
module lcd_rgb_orderer_chk #(
  parameter int COMP_W = 8,
  parameter int N_COMP = 3
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [1:0]               out_sel_i,
  input logic [1:0]               disp_mode_i,
  input logic                     pix_valid_i,
  input logic                     pix_ready_o,
  input logic [COMP_W*N_COMP-1:0] pix_data_i,
  input logic [COMP_W*N_COMP-1:0] lcd_data_o,
  input logic                     lcd_de_o,
  input logic                     lcd_first_o
);
  logic acc, acc_ser;
  assign acc     = pix_valid_i & pix_ready_o;
  assign acc_ser = acc & (out_sel_i == 2'b00) & disp_mode_i[1];

  p_idle_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lcd_de_o |-> (lcd_data_o == '0) && !lcd_first_o);

  p_first_needs_de_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcd_first_o |-> lcd_de_o);

  p_accept_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> lcd_de_o && lcd_first_o);

  p_serial_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ser |=> !pix_ready_o ##1 !pix_ready_o);

  p_parallel_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !acc_ser) |=> pix_ready_o);

  p_serial_upper_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ser |=> (lcd_data_o[COMP_W*N_COMP-1:COMP_W] == '0));

  p_pix_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcd_de_o && !lcd_first_o) |-> lcd_data_o[COMP_W*N_COMP-1:COMP_W] == '0);
endmodule

bind lcd_rgb_orderer lcd_rgb_orderer_chk #(.COMP_W(COMP_W), .N_COMP(N_COMP)) u_chk (.*);

// File: tb/lcd_rgb_orderer_tb.sv
`timescale 1ns/1ps
module lcd_rgb_orderer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  out_sel_i = 2'b00;
  logic [1:0]  disp_mode_i = 2'b00;
  logic        pix_valid_i = 1'b0;
  logic        pix_ready_o;
  logic [23:0] pix_data_i = '0;
  logic [23:0] lcd_data_o;
  logic        lcd_de_o;
  logic        lcd_first_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  lcd_rgb_orderer u_dut (.*);

  function automatic logic [23:0] bgr(logic [23:0] p);
    return {p[7:0], p[15:8], p[23:16]};
  endfunction
  function automatic logic [23:0] lo(logic [7:0] b);
    return {16'h0, b};
  endfunction

  task automatic chk(string req, logic [23:0] ed, logic ede, logic efirst, logic erdy);
    n_chk++;
    if (lcd_data_o !== ed || lcd_de_o !== ede || lcd_first_o !== efirst || pix_ready_o !== erdy) begin
      n_err++;
      $display("FAIL %s: data=%h de=%b first=%b rdy=%b expected data=%h de=%b first=%b rdy=%b",
               req, lcd_data_o, lcd_de_o, lcd_first_o, pix_ready_o, ed, ede, efirst, erdy);
    end
  endtask

  // accept one pixel; returns at the negedge where the first output is visible
  task automatic push(logic [1:0] sel, logic [1:0] mode, logic [23:0] p);
    @(negedge clk_i);
    out_sel_i = sel; disp_mode_i = mode; pix_data_i = p; pix_valid_i = 1'b1;
    @(negedge clk_i);
    pix_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk("R1", 24'h0, 0, 0, 1);
  endtask

  task automatic t_par_rgb();
    push(2'b00, 2'b00, 24'h123456);
    chk("R2", 24'h123456, 1, 1, 1);
    @(negedge clk_i);
    chk("R10", 24'h0, 0, 0, 1);
  endtask

  task automatic t_par_bgr();
    push(2'b00, 2'b01, 24'hA1B2C3);
    chk("R3", bgr(24'hA1B2C3), 1, 1, 1);
    @(negedge clk_i);
    chk("R10", 24'h0, 0, 0, 1);
  endtask

  task automatic t_serial(logic rev, logic [23:0] p);
    string r = rev ? "R5" : "R4";
    push(2'b00, {1'b1, rev}, p);
    chk(r, lo(rev ? p[7:0]   : p[23:16]), 1, 1, 0);
    @(negedge clk_i);
    chk(r, lo(p[15:8]), 1, 0, 0);
    @(negedge clk_i);
    chk(r, lo(rev ? p[23:16] : p[7:0]), 1, 0, 1);
    @(negedge clk_i);
    chk("R10", 24'h0, 0, 0, 1);
  endtask

  task automatic t_forced_parallel();
    for (int s = 1; s < 4; s++) begin
      push(2'(s), 2'b11, 24'h0F1E2D + 24'(s));
      chk("R6", 24'h0F1E2D + 24'(s), 1, 1, 1);
    end
    push(2'b10, 2'b10, 24'h556677);
    chk("R6", 24'h556677, 1, 1, 1);
    @(negedge clk_i);
  endtask

  task automatic t_serial_stream();
    logic [23:0] p0 = 24'hC0FFEE, p1 = 24'hBADA55;
    @(negedge clk_i);
    out_sel_i = 2'b00; disp_mode_i = 2'b10; pix_data_i = p0; pix_valid_i = 1'b1;
    @(negedge clk_i); chk("R7", lo(p0[23:16]), 1, 1, 0);
    @(negedge clk_i); chk("R7", lo(p0[15:8]),  1, 0, 0);
    @(negedge clk_i); chk("R7", lo(p0[7:0]),   1, 0, 1);
    pix_data_i = p1;
    @(negedge clk_i); chk("R8", lo(p1[23:16]), 1, 1, 0);
    @(negedge clk_i); chk("R8", lo(p1[15:8]),  1, 0, 0);
    @(negedge clk_i); chk("R8", lo(p1[7:0]),   1, 0, 1);
    pix_valid_i = 1'b0;
    @(negedge clk_i); chk("R10", 24'h0, 0, 0, 1);
  endtask

  task automatic t_parallel_stream();
    @(negedge clk_i);
    out_sel_i = 2'b00; disp_mode_i = 2'b00; pix_valid_i = 1'b1;
    pix_data_i = 24'h010203;
    for (int i = 1; i < 5; i++) begin
      @(negedge clk_i);
      chk("R7", 24'h010203 * 24'(i), 1, 1, 1);
      pix_data_i = 24'h010203 * 24'(i + 1);
    end
    pix_valid_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic t_midchange();
    logic [23:0] p = 24'h7788AA;
    push(2'b00, 2'b11, p);
    chk("R9", lo(p[7:0]), 1, 1, 0);
    out_sel_i = 2'b10; disp_mode_i = 2'b00; pix_data_i = 24'hFFFFFF;
    @(negedge clk_i); chk("R9", lo(p[15:8]), 1, 0, 0);
    disp_mode_i = 2'b10; out_sel_i = 2'b00;
    @(negedge clk_i); chk("R9", lo(p[23:16]), 1, 0, 1);
    @(negedge clk_i); chk("R10", 24'h0, 0, 0, 1);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1", 24'h0, 0, 0, 1);
    #10 rst_ni = 1'b1;
    t_reset();
    t_par_rgb();
    t_par_bgr();
    t_serial(1'b0, 24'h3C5A7E);
    t_serial(1'b1, 24'h3C5A7E);
    t_forced_parallel();
    t_serial_stream();
    t_parallel_stream();
    t_midchange();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule